// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a narrow window of four 32-bit words through which it can reach a remote 32-bit register space. The host never touches the remote space directly. It loads a target address into the window, and write data too if it is writing. It then writes a command word that asks for a single read or a single write. The bridge runs that one access on a request/response back-end bus and raises an acknowledge flag in the command word when the access completes. For a read, the fetched value is already in the read-data word at that point.

The host polls the command word until the acknowledge flag shows. It collects the result and then writes zero to the command word, which puts the bridge back to idle. A zero write is always accepted, including during a pending access and straight after start-up. Any other command that arrives while an access is pending or acknowledged is dropped.

The back end works like a valid/ready stream with the response as the ready:
- Once `req_valid` rises, it and the request fields stay constant until the cycle in which `rsp_valid` is high.
- `rsp_valid` is a single-cycle pulse.
- A pulse that arrives while no request is pending is ignored.

Top module: `regwin_bridge`

## Requirements
- R1: After reset, all four window words read as zero and `req_valid` is low.
- R2: The window decodes the word-aligned byte offsets 0x0 (command), 0x4 (address), 0x8 (read data) and 0xC (write data). An offset with nonzero low two bits reads zero and is not written. The address and write-data words read back what was last written. A host write to the read-data word has no effect. The command word reads {bit2 = acknowledge, bit1 = write pending, bit0 = read pending}, and all higher bits read zero.
- R3: A command write whose bits [1:0] are 01, accepted while idle, issues one back-end request with `req_we` low. In the response cycle, `rsp_rdata` is captured into the read-data word and the acknowledge bit is set, so both become visible in the same following cycle. The command word then reads 0x5.
- R4: A command write whose bits [1:0] are 10, accepted while idle, issues one back-end request with `req_we` high and `req_wdata` equal to the write-data word. After the response the command word reads 0x6.
- R5: `req_addr`, `req_wdata` and `req_we` are latched from the window when the command is accepted. They stay stable while `req_valid` is high and no response has arrived, even if the host rewrites the address or write-data word.
- R6: A host write of zero to the command word, in any state, makes the command word read exactly zero and `req_valid` read low from the next cycle on.
- R7: A nonzero command write is ignored while a request is pending or the acknowledge bit is set. The command word and the back-end outputs are left unchanged.
- R8: A command write whose bits [1:0] are 11 or 00, with some bit set, issues no request and leaves the command word at zero.
- R9: The target address reaches `req_addr` unchanged across the whole word-aligned range 0x000 to 0xFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wen | input | 1 | Host write strobe for one window word |
| host_addr | input | 4 | Window byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Window word at `host_addr` (combinational) |
| req_valid | output | 1 | Back-end request pending |
| req_we | output | 1 | Request is a write |
| req_addr | output | 32 | Request target address |
| req_wdata | output | 32 | Request write data |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_rdata | input | 32 | Read data, valid with `rsp_valid` |

## Verification
The main function is tried as a sequence of reads and writes, and several things vary between them:
- **Response latency (zero to several cycles):** shows whether the acknowledge bit waits for the response rather than for a fixed delay.
- **Target address (both ends of the range, plus interior words):** shows whether the address is passed on unmodified.
- **Write followed by read of the same word:** shows whether write data actually reaches the remote word.

Directed cases then cover the remaining behaviour:
- rewriting the address and data words during a slow write, which separates snapshotting from forwarding live values;
- commands issued while a request is pending or acknowledged;
- the both-bits and no-bits command codes;
- a clear issued during a pending access.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_BUSY = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_t;

  localparam int WORD_CMD   = 0;
  localparam int WORD_ADDR  = 1;
  localparam int WORD_RDATA = 2;
  localparam int WORD_WDATA = 3;
  localparam int NUM_WORDS  = 4;

  localparam int BIT_RD  = 0;
  localparam int BIT_WR  = 1;
  localparam int BIT_ACK = 2;
endpackage

// File: rtl/regwin_csr.sv
module regwin_csr
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIN_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wen,
  input  logic [WIN_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] cmd_word,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              cmd_wr,
  output logic              cmd_zero,
  output logic [1:0]        cmd_req
);
  localparam int IDX_W = WIN_AW - 2;

  logic [IDX_W-1:0]  word_idx;
  logic              aligned;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] words  [NUM_WORDS];
  logic [DATA_W-1:0] masked [NUM_WORDS];

  assign word_idx = host_addr[WIN_AW-1:2];
  assign aligned  = (host_addr[1:0] == 2'b00);

  assign cmd_wr   = host_wen && aligned && (word_idx == IDX_W'(WORD_CMD));
  assign cmd_zero = (host_wdata == '0);
  assign cmd_req  = host_wdata[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (host_wen && aligned && (word_idx == IDX_W'(WORD_ADDR)))
        addr_q <= host_wdata;
      if (host_wen && aligned && (word_idx == IDX_W'(WORD_WDATA)))
        wdata_q <= host_wdata;
      if (cap_en)
        rdata_q <= cap_data;
    end
  end

  assign words[WORD_CMD]   = cmd_word;
  assign words[WORD_ADDR]  = addr_q;
  assign words[WORD_RDATA] = rdata_q;
  assign words[WORD_WDATA] = wdata_q;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_sel
    assign masked[g] = (aligned && (word_idx == IDX_W'(g))) ? words[g] : '0;
  end

  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      host_rdata = host_rdata | masked[i];
  end
endmodule

// File: rtl/regwin_engine.sv
module regwin_engine
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_zero,
  input  logic [1:0]        cmd_req,
  input  logic [DATA_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] cmd_word,
  output logic              cap_en,
  output logic              req_valid,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid
);
  eng_state_t state_q;
  logic       op_rd_q, op_wr_q, ack_q;
  logic       do_clear, start_rd, start_wr;

  assign do_clear = cmd_wr && cmd_zero;
  assign start_rd = cmd_wr && (cmd_req == 2'b01);
  assign start_wr = cmd_wr && (cmd_req == 2'b10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ENG_IDLE;
      op_rd_q   <= 1'b0;
      op_wr_q   <= 1'b0;
      ack_q     <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else if (do_clear) begin
      state_q <= ENG_IDLE;
      op_rd_q <= 1'b0;
      op_wr_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (start_rd || start_wr) begin
            state_q   <= ENG_BUSY;
            op_rd_q   <= start_rd;
            op_wr_q   <= start_wr;
            req_addr  <= addr_q[ADDR_W-1:0];
            req_wdata <= wdata_q;
          end
        end
        ENG_BUSY: begin
          if (rsp_valid) begin
            state_q <= ENG_DONE;
            ack_q   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign req_valid = (state_q == ENG_BUSY);
  assign req_we    = op_wr_q;
  assign cap_en    = req_valid && rsp_valid && op_rd_q && !do_clear;

  always_comb begin
    cmd_word          = '0;
    cmd_word[BIT_RD]  = op_rd_q;
    cmd_word[BIT_WR]  = op_wr_q;
    cmd_word[BIT_ACK] = ack_q;
  end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WIN_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wen,
  input  logic [WIN_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              req_valid,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] cmd_word;
  logic [DATA_W-1:0] addr_q, wdata_q;
  logic              cap_en, cmd_wr, cmd_zero;
  logic [1:0]        cmd_req;

  regwin_csr #(.DATA_W(DATA_W), .WIN_AW(WIN_AW)) csr_i (
    .clk(clk), .rst_n(rst_n),
    .host_wen(host_wen), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cmd_word(cmd_word),
    .cap_en(cap_en), .cap_data(rsp_rdata),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .cmd_wr(cmd_wr), .cmd_zero(cmd_zero), .cmd_req(cmd_req)
  );

  regwin_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_zero(cmd_zero), .cmd_req(cmd_req),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .cmd_word(cmd_word), .cap_en(cap_en),
    .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid)
  );
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WIN_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wen,
  input logic [WIN_AW-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] cmd_word
);
  logic cmd_hit, clr;
  assign cmd_hit = host_wen && (host_addr == '0);
  assign clr     = cmd_hit && (host_wdata == '0);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid && !clr) |=>
      (req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_we)));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cmd_word == '0) && !req_valid);

  assert_ack_after_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_valid && !clr) |=> cmd_word[2] && !req_valid);

  assert_ack_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_word[2]) |-> $past(req_valid && rsp_valid));

  assert_one_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_word[1:0]));

  assert_invalid_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && (host_wdata[1:0] == 2'b11) && (cmd_word == '0)) |=>
      !req_valid && (cmd_word == '0));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !clr && (cmd_word != '0) && !rsp_valid) |=> $stable(cmd_word));
endmodule

bind regwin_bridge regwin_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wen(host_wen), .host_addr(host_addr),
  .host_wdata(host_wdata), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .cmd_word(cmd_word)
);

// File: tb/regwin_bridge_tb_top.sv
`timescale 1ns/1ps
module regwin_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wen = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        req_valid, req_we;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  always #2.5 clk = ~clk;

  regwin_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_wen(host_wen), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int errors = 0;
  int checks = 0;

  // Remote register space model and back-end responder
  logic [31:0] mem [1024];
  int          rsp_lat = 0;
  logic        rsp_hold = 1'b0;
  int          log_cnt = 0;
  logic [31:0] log_addr, log_wdata;
  logic        log_we;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0001_0203);
    log_addr = '0; log_wdata = '0; log_we = 1'b0;
  end

  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (req_valid && !rsp_hold) begin
        if (cnt >= rsp_lat) begin
          rsp_valid = 1'b1;
          rsp_rdata = mem[req_addr[11:2]];
          if (req_we) mem[req_addr[11:2]] = req_wdata;
          log_addr = req_addr; log_wdata = req_wdata; log_we = req_we;
          log_cnt++;
          cnt = 0;
        end else cnt++;
      end else cnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [3:0] off, input logic [31:0] val);
    @(negedge clk);
    host_wen = 1'b1; host_addr = off; host_wdata = val;
    @(posedge clk);
    #1 host_wen = 1'b0;
  endtask

  task automatic hrd(input logic [3:0] off, output logic [31:0] val);
    @(negedge clk);
    host_addr = off;
    #1 val = host_rdata;
  endtask

  task automatic wait_ack(output logic [31:0] val);
    for (int i = 0; i < 60; i++) begin
      hrd(4'h0, val);
      if (val[2]) break;
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [3:0]  lat;
    logic [31:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 4'd0, 32'h0000_0000, 32'h0},
    '{1'b0, 4'd3, 32'h0000_0FFC, 32'h0},
    '{1'b1, 4'd1, 32'h0000_0100, 32'hDEAD_BEEF},
    '{1'b0, 4'd2, 32'h0000_0100, 32'h0},
    '{1'b1, 4'd0, 32'h0000_0FFC, 32'h1234_5678},
    '{1'b0, 4'd5, 32'h0000_0FFC, 32'h0},
    '{1'b1, 4'd4, 32'h0000_0004, 32'h0F0F_A5A5},
    '{1'b0, 4'd1, 32'h0000_0004, 32'h0}
  };

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, exp;
    int          n0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int w = 0; w < 4; w++) begin
      hrd(4'(w * 4), v);
      chk("R1 window word zero", v, 32'h0);
    end
    chk("R1 no request", {31'h0, req_valid}, 32'h0);

    // Vector table: main read/write function
    for (int k = 0; k < 8; k++) begin
      rsp_lat = int'(VEC[k].lat);
      hrd(4'h0, v);
      chk("R6 idle before access", v, 32'h0);
      exp = mem[VEC[k].addr[11:2]];
      if (VEC[k].we) hwr(4'hC, VEC[k].data);
      hwr(4'h4, VEC[k].addr);
      hwr(4'h0, VEC[k].we ? 32'h2 : 32'h1);
      wait_ack(v);
      if (VEC[k].we) begin
        chk("R4 ack word after write", v, 32'h6);
        chk("R4 remote word written", mem[VEC[k].addr[11:2]], VEC[k].data);
        chk("R4 request was write", {31'h0, log_we}, 32'h1);
      end else begin
        chk("R3 ack word after read", v, 32'h5);
        hrd(4'h8, v);
        chk("R3 read data", v, exp);
        chk("R3 request was read", {31'h0, log_we}, 32'h0);
      end
      chk("R9 address passed unchanged", log_addr, VEC[k].addr);
      hwr(4'h0, 32'h0);
      hrd(4'h0, v);
      chk("R6 cleared word", v, 32'h0);
    end

    // R2 readback, read-only data word, unaligned offset
    hwr(4'h4, 32'h0000_0ABC);
    hwr(4'hC, 32'h5A5A_0001);
    hrd(4'h4, v); chk("R2 address readback", v, 32'h0000_0ABC);
    hrd(4'hC, v); chk("R2 wdata readback", v, 32'h5A5A_0001);
    hrd(4'h8, exp);
    hwr(4'h8, 32'hFFFF_FFFF);
    hrd(4'h8, v); chk("R2 read-data word not host writable", v, exp);
    hwr(4'h5, 32'h1111_1111);
    hrd(4'h4, v); chk("R2 unaligned write ignored", v, 32'h0000_0ABC);
    hrd(4'h5, v); chk("R2 unaligned read zero", v, 32'h0);

    // R5 request snapshot while host rewrites window
    rsp_lat = 6;
    hwr(4'hC, 32'hCAFE_0011);
    hwr(4'h4, 32'h0000_0200);
    hwr(4'h0, 32'h2);
    hwr(4'h4, 32'h0000_0300);
    hwr(4'hC, 32'hBAD0_BAD0);
    wait_ack(v);
    chk("R5 snapshot address", log_addr, 32'h0000_0200);
    chk("R5 snapshot data", log_wdata, 32'hCAFE_0011);
    chk("R5 untouched neighbour", mem[32'h300 >> 2], 32'hA500_0000 ^ (32'hC0 * 32'h0001_0203));
    hrd(4'h4, v); chk("R2 address holds new value", v, 32'h0000_0300);

    // R7 command while acknowledged
    n0 = log_cnt;
    hwr(4'h0, 32'h1);
    repeat (3) @(posedge clk);
    hrd(4'h0, v); chk("R7 ignored while acked", v, 32'h6);
    chk("R7 no new request while acked", {31'h0, req_valid}, 32'h0);
    chk("R7 no response count change", 32'(log_cnt), 32'(n0));
    hwr(4'h0, 32'h0);

    // R7 command while busy, then R6 clear mid-transaction
    rsp_hold = 1'b1;
    hwr(4'h0, 32'h1);
    hwr(4'h0, 32'h2);
    hrd(4'h0, v); chk("R7 ignored while busy", v, 32'h1);
    chk("R7 request kind unchanged", {31'h0, req_we}, 32'h0);
    hwr(4'h0, 32'h0);
    hrd(4'h0, v); chk("R6 clear during pending access", v, 32'h0);
    chk("R6 request dropped", {31'h0, req_valid}, 32'h0);
    rsp_hold = 1'b0;
    repeat (3) @(posedge clk);
    chk("R6 no late response", 32'(log_cnt), 32'(n0 + 0));

    // R8 invalid command codes
    hwr(4'h0, 32'h3);
    repeat (3) @(posedge clk);
    hrd(4'h0, v); chk("R8 both bits ignored", v, 32'h0);
    chk("R8 no request for both bits", {31'h0, req_valid}, 32'h0);
    hwr(4'h0, 32'h4);
    repeat (2) @(posedge clk);
    hrd(4'h0, v); chk("R8 ack-only command ignored", v, 32'h0);
    chk("R8 no response issued", 32'(log_cnt), 32'(n0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule